// File: doc/BRIEF.md
# Frozen-Read Time Register Snapshot

This block keeps two copies of the time of day. The internal copy is a BCD counter that advances by one second on each seconds tick, with carries from seconds to minutes to hours. The bus-visible copy is what a host sees through a small parallel register port: one byte per field, for seconds, minutes, hours, weekday, date, month, year and century.

A host that wants a coherent timestamp sets the freeze bit, which is bit 6 of the century byte. While that bit is set, the visible copy holds the time that was current when the freeze began. The internal count keeps running, so reading the clock never costs accuracy. When the host clears the bit, a dwell timer counts microsecond ticks. Once the dwell has elapsed, every visible field is reloaded from the internal count in a single cycle. After that, the visible copy follows the internal count on every seconds tick.

Top module: `rtc_snapshot`

## Requirements
- R1: After reset, every register reads 0x00 and the freeze bit is 0.
- R2: The register map is: address 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 century. Each register is one byte of packed BCD, and reads return data combinationally on `rdata_o`.
- R3: While the freeze bit is 1, reads of addresses 0 to 6 return the values that were visible when the bit was set, whatever seconds ticks arrive.
- R4: The internal count advances on every seconds tick, including while the freeze bit is 1, so the first refresh after a freeze shows the time including every tick that arrived during the freeze.
- R5: A refresh loads all seven time fields in the same cycle, from the internal value that includes any seconds tick or host write in that cycle.
- R6: After the freeze bit is cleared, no refresh happens until DWELL_US microsecond ticks have arrived with the bit at 0. The refresh occurs in the cycle of the DWELL_US-th tick.
- R7: Once the dwell has elapsed and the freeze bit is 0, the visible copy is refreshed on every seconds tick and equals the new internal time.
- R8: Setting the freeze bit before the dwell has elapsed cancels the pending refresh. On the next clear, the dwell count starts again from zero.
- R9: Reading address 7 returns the freeze bit in bit 6 and the last written century value in bits 7 and 5..0. A write to address 7 sets both parts.
- R10: Seconds wrap from 59 to 00 with a carry into minutes, minutes wrap from 59 to 00 with a carry into hours, and hours wrap from 23 to 00. Weekday, date, month and year do not change on any wrap.
- R11: A write to address 0 to 6 sets that internal field, and the new value becomes visible at the next refresh. A write in the same cycle as a seconds tick overrides the incremented value of the written field only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse every microsecond |
| sec_tick_i | input | 1 | One-cycle pulse every second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |

## Verification
Two events can land in the same clock cycle: the microsecond tick that ends the dwell, and the seconds tick that advances the internal count. The bench freezes the copy, lets seconds pass, clears the bit, and then delivers the last dwell tick together with a seconds tick in a single cycle. The check passes only if the visible time equals the model time after that tick, which means the refresh took the incremented value rather than the stale one. A host write that coincides with a seconds tick is judged in the same way: the written field must take the host value, and the other fields must show the increment.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;
  localparam int NF        = 7;   // time fields at addresses 0..NF-1
  localparam int NCNT      = 3;   // counted fields: sec, min, hour
  localparam int AW        = 3;
  localparam int CENT_ADDR = 7;

  typedef logic [7:0] bcd_t;
  typedef logic [NF-1:0][7:0] time_t;

  function automatic bcd_t field_max(input int idx);
    case (idx)
      0, 1:    return 8'h59;
      default: return 8'h23;
    endcase
  endfunction

  function automatic bcd_t bcd_inc(input bcd_t v, input bcd_t lim);
    if (v == lim)           return 8'h00;
    else if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    else                    return v + 8'h01;
  endfunction
endpackage

// File: rtl/rtc_dwell_timer.sv
module rtc_dwell_timer #(
  parameter int DWELL_US = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic us_tick_i,
  output logic expire_o,
  output logic done_o
);
  localparam int CW = $clog2(DWELL_US + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          last;

  assign last     = us_tick_i && !done_q && (cnt_q == CW'(DWELL_US - 1));
  assign expire_o = !hold_i && last;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;   // any set restarts the dwell
      done_q <= 1'b0;
    end else if (us_tick_i && !done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_snap_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sec_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  bcd_t          wdata_i,
  output time_t         int_o,
  output time_t         nxt_o
);
  time_t           int_q, inc;
  logic [NCNT:0]   carry;

  assign carry[0] = sec_tick_i;

  for (genvar i = 0; i < NF; i++) begin : g_field
    if (i < NCNT) begin : g_cnt
      assign inc[i]       = carry[i] ? bcd_inc(int_q[i], field_max(i)) : int_q[i];
      assign carry[i+1]   = carry[i] && (int_q[i] == field_max(i));
    end else begin : g_hold
      assign inc[i] = int_q[i];
    end
  end

  always_comb begin
    nxt_o = inc;
    for (int i = 0; i < NF; i++)
      if (wr_en_i && wr_idx_i == AW'(i)) nxt_o[i] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= '0;
    else         int_q <= nxt_o;
  end

  assign int_o = int_q;
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_snap_pkg::*;
#(
  parameter int DWELL_US = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          us_tick_i,
  input  logic          sec_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  time_t      vis_q, int_q, int_nx;
  logic       rd_q;
  logic [6:0] cent_q;
  logic       wr_time, wr_cent;
  logic       expire, dwell_done, xfer;

  assign wr_cent = wr_en_i && (addr_i == AW'(CENT_ADDR));
  assign wr_time = wr_en_i && (addr_i < AW'(NF));

  rtc_time_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick_i),
    .wr_en_i    (wr_time),
    .wr_idx_i   (addr_i),
    .wdata_i    (wdata_i),
    .int_o      (int_q),
    .nxt_o      (int_nx)
  );

  rtc_dwell_timer #(.DWELL_US(DWELL_US)) u_dwell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (rd_q),
    .us_tick_i (us_tick_i),
    .expire_o  (expire),
    .done_o    (dwell_done)
  );

  // load the post-tick value so no field is caught mid-increment
  assign xfer = !rd_q && (expire || (dwell_done && sec_tick_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q  <= '0;
      rd_q   <= 1'b0;
      cent_q <= '0;
    end else begin
      if (xfer) vis_q <= int_nx;
      if (wr_cent) begin
        rd_q   <= wdata_i[6];
        cent_q <= {wdata_i[7], wdata_i[5:0]};
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NF; i++)
      if (addr_i == AW'(i)) rdata_o = vis_q[i];
    if (addr_i == AW'(CENT_ADDR)) rdata_o = {cent_q[6], rd_q, cent_q[5:0]};
  end
endmodule

// File: rtl/rtc_snapshot_chk.sv
module rtc_snapshot_chk
  import rtc_snap_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sec_tick_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic          rd_q,
  input logic          xfer,
  input logic          dwell_done,
  input time_t         vis_q,
  input time_t         int_q,
  input time_t         int_nx
);
  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> $stable(vis_q));

  assert_keeps_counting_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && !(wr_en_i && addr_i == '0)) |=> (int_q[0] != $past(int_q[0])));

  assert_whole_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |=> (vis_q == $past(int_nx)));

  assert_dwell_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |=> !dwell_done);

  assert_no_xfer_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer |-> !rd_q);

  assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(vis_q));
endmodule

bind rtc_snapshot rtc_snapshot_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sec_tick_i (sec_tick_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .rd_q       (rd_q),
  .xfer       (xfer),
  .dwell_done (dwell_done),
  .vis_q      (vis_q),
  .int_q      (int_q),
  .int_nx     (int_nx)
);

// File: tb/rtc_snapshot_tb.sv
module rtc_snapshot_tb;
  localparam int DW = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       us_tick = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;

  int checks = 0, errors = 0;
  int s = 0, m = 0, h = 0;
  logic [7:0] wday = 0, date = 0, mon = 0, yr = 0;

  always #10 clk = ~clk;

  rtc_snapshot #(.DWELL_US(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .us_tick_i(us_tick), .sec_tick_i(sec_tick),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [7:0] bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [23:0] exp_time();
    return {bcd(h), bcd(m), bcd(s)};
  endfunction

  task automatic advance();
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) h = 0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d, input bit st, input bit ut);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; sec_tick = st; us_tick = ut;
    @(negedge clk);
    wr_en = 1'b0; sec_tick = 1'b0; us_tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic read_time(output logic [23:0] t);
    logic [7:0] hh, mm, ss;
    rd(3'd2, hh); rd(3'd1, mm); rd(3'd0, ss);
    t = {hh, mm, ss};
  endtask

  initial begin
    #3ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [23:0] t, snap;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state, R2 map
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 R2 reset read", v, 0);
    end

    // first dwell after reset
    repeat (DW) cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);

    // R7 R10 sweep across minute and hour rollovers
    for (int n = 0; n < 3700; n++) begin
      cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
      advance();
      read_time(t);
      check(t == exp_time(), "R7 R10 sweep", t, exp_time());
    end

    // R11 host sets date and time; visible waits for next refresh
    wr(3'd3, 8'h03); wr(3'd4, 8'h15); wr(3'd5, 8'h07); wr(3'd6, 8'h24);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    rd(3'd0, v);
    check(v == bcd(s), "R11 write not yet visible", v, bcd(s));
    h = 23; m = 59; s = 58; wday = 8'h03; date = 8'h15; mon = 8'h07; yr = 8'h24;
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0); advance();
    read_time(t);
    check(t == exp_time(), "R11 written time visible", t, exp_time());
    rd(3'd3, v);
    check(v == wday, "R11 weekday", v, wday);

    // R10 day rollover leaves calendar fields alone
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0); advance();
    read_time(t);
    check(t == 24'h000000, "R10 hour wrap", t, 24'h000000);
    rd(3'd4, v); check(v == date, "R10 date kept", v, date);
    rd(3'd5, v); check(v == mon,  "R10 month kept", v, mon);
    rd(3'd6, v); check(v == yr,   "R10 year kept", v, yr);

    // R9 century register and freeze
    wr(3'd7, 8'h60);
    rd(3'd7, v);
    check(v == 8'h60, "R9 century with freeze", v, 8'h60);
    snap = exp_time();
    for (int n = 0; n < 125; n++) begin
      cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0); advance();
      read_time(t);
      check(t == snap, "R3 frozen", t, snap);
    end
    wr(3'd7, 8'h20);
    rd(3'd7, v);
    check(v == 8'h20, "R9 century after clear", v, 8'h20);

    // R6 dwell
    for (int n = 0; n < DW - 1; n++) begin
      cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
      read_time(t);
      check(t == snap, "R6 dwell not elapsed", t, snap);
    end
    cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    read_time(t);
    check(t == exp_time(), "R4 R6 refresh after dwell", t, exp_time());

    // R8 cancel and restart
    wr(3'd7, 8'h60);
    snap = exp_time();
    repeat (3) begin cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0); advance(); end
    wr(3'd7, 8'h20);
    repeat (DW - 2) cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    wr(3'd7, 8'h60);
    wr(3'd7, 8'h20);
    repeat (DW - 1) cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    read_time(t);
    check(t == snap, "R8 cancelled refresh", t, snap);
    cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    read_time(t);
    check(t == exp_time(), "R8 restarted dwell", t, exp_time());

    // R5 dwell end and seconds tick in one cycle
    wr(3'd7, 8'h60);
    snap = exp_time();
    repeat (2) begin cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0); advance(); end
    wr(3'd7, 8'h20);
    repeat (DW - 1) cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    read_time(t);
    check(t == snap, "R5 still frozen", t, snap);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1); advance();
    read_time(t);
    check(t == exp_time(), "R5 coincident tick loaded", t, exp_time());

    // R11 write coinciding with a seconds tick
    cyc(1'b1, 3'd0, 8'h30, 1'b1, 1'b0); advance(); s = 30;
    read_time(t);
    check(t == exp_time(), "R11 write over tick", t, exp_time());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule